// File: doc/BRIEF.md
# Quad-Add Sequencer

This block produces `(4*a + b) mod 16` for two 4-bit unsigned operands without a multiplier. A small control state machine drives a datapath made of a 4-bit accumulator, a 4-bit adder whose carry-out is dropped, and a modulo-4 step counter. The counter raises a terminal flag on its last count, and that flag tells the controller to stop adding.

A caller presents `op_a` and `op_b` and raises `start` while the block is idle. The operands are captured on that edge and kept inside the block for the whole run. The block then copies `b` into the accumulator and adds `a` to it four times. It reports completion with a one-cycle `done` pulse. The result stays on `result` until the next accepted start.

The controller has four states. `ST_IDLE` waits. Its transition *accept* (taken when `start` is 1) goes to `ST_LOAD`, and its transition *wait* (taken when `start` is 0) stays in `ST_IDLE`. `ST_LOAD` copies `b` into the accumulator and takes *begin* to `ST_ADD`. `ST_ADD` adds `a` and advances the counter. It takes *repeat* back to itself until the counter's terminal flag is set, and then takes *finish* to `ST_DONE`. `ST_DONE` raises `done` and takes *rearm* to `ST_IDLE`.

Top module: `quad_add_seq`

## Requirements
- R1: While reset is asserted and after reset, `done` is 0 and `result` is 0.
- R2: A 1 on `start` in the idle state captures `op_a` and `op_b`. On the next edge, the captured `b` is placed in the accumulator.
- R3: Each add step places accumulator plus captured `a` into the accumulator and advances the step counter. Exactly four add steps occur per run.
- R4: If `start` is sampled high in idle at edge N, then `done` is high from edge N+5 to edge N+6 and low at all other times.
- R5: While `done` is high, `result` equals `(4*a + b)` taken modulo 16, using the captured operands. Adder carries are discarded.
- R6: After `done`, `result` keeps its value until another start is accepted.
- R7: While a run is in progress (states load, add and done), `start` and changes on `op_a`/`op_b` have no effect on that run's result, and they do not create an extra `done`.
- R8: The step counter is back at 0 when `done` is raised. A start accepted on the first idle cycle after `done` therefore gives a correct result with the same timing.
- R9: With `start` held at 0, the block stays idle: no `done` is produced and `result` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests a computation; acted on only in idle |
| op_a | input | 4 | Operand added four times |
| op_b | input | 4 | Operand used as the initial accumulator value |
| result | output | 4 | Accumulator contents |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a run that is disturbed while it is busy: a second `start` together with new operand values, arriving while the controller is in its add loop. The stimulus makes this happen by pulsing `start` and inverting both operands two cycles after a start has been accepted. It then requires exactly one `done` carrying the original operands' result. A second difficult case is a start issued on the very first idle cycle after `done`. Back-to-back runs are driven that way, so any counter left off zero would show up as a wrong sum or a shifted `done`.

// File: rtl/qa_pkg.sv
package qa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_ADD  = 2'd2,
        ST_DONE = 2'd3
    } qa_state_e;

    typedef struct packed {
        logic grab;   // capture operands
        logic ld_b;   // accumulator <= b
        logic step;   // accumulator <= acc + a, counter advance
        logic fin;    // completion pulse
    } qa_ctl_t;
endpackage

// File: rtl/qa_iter_cnt.sv
module qa_iter_cnt #(
    parameter int STEPS = 4,
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam logic [CW-1:0] TERM = CW'(STEPS - 1);

    assign last = (cnt == TERM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            if (last) cnt <= '0;
            else      cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/qa_accum.sv
module qa_accum #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_b,
    input  logic          step,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    output logic [DW-1:0] acc
);
    logic [DW-1:0] sum;

    // DW-bit add: carry out is dropped, result wraps
    assign sum = acc + a_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    acc <= '0;
        else if (ld_b) acc <= b_in;
        else if (step) acc <= sum;
    end
endmodule

// File: rtl/qa_ctrl.sv
module qa_ctrl
    import qa_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      last,
    output qa_state_e state,
    output qa_ctl_t   ctl
);
    qa_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_LOAD;   // accept / wait
            ST_LOAD: nxt = ST_ADD;               // begin
            ST_ADD:  if (last) nxt = ST_DONE;    // finish / repeat
            ST_DONE: nxt = ST_IDLE;              // rearm
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_IDLE: ctl.grab = start;
            ST_LOAD: ctl.ld_b = 1'b1;
            ST_ADD:  ctl.step = 1'b1;
            ST_DONE: ctl.fin  = 1'b1;
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/quad_add_seq.sv
module quad_add_seq
    import qa_pkg::*;
#(
    parameter int DW    = 4,
    parameter int STEPS = 4,
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] result,
    output logic          done
);
    qa_state_e     st;
    qa_ctl_t       ctl;
    logic          last;
    logic [CW-1:0] cnt;
    logic [DW-1:0] a_q, b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (ctl.grab) begin
            a_q <= op_a;
            b_q <= op_b;
        end
    end

    qa_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .last  (last),
        .state (st),
        .ctl   (ctl)
    );

    qa_iter_cnt #(.STEPS(STEPS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ctl.step),
        .cnt   (cnt),
        .last  (last)
    );

    qa_accum #(.DW(DW)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_b  (ctl.ld_b),
        .step  (ctl.step),
        .a_in  (a_q),
        .b_in  (b_q),
        .acc   (result)
    );

    assign done = ctl.fin;
endmodule

// File: rtl/qa_checker.sv
module qa_checker
    import qa_pkg::*;
#(
    parameter int DW    = 4,
    parameter int STEPS = 4,
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic [DW-1:0] result,
    input qa_state_e     state,
    input logic [DW-1:0] a_q,
    input logic [DW-1:0] b_q,
    input logic [CW-1:0] cnt
);
    logic [DW-1:0] want;
    assign want = DW'(int'(a_q) * STEPS + int'(b_q));

    assert_load_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOAD |=> result == $past(b_q));

    assert_add_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ADD |=> result == DW'($past(result) + $past(a_q)));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result == want);

    assert_ops_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE |=> $stable(a_q) && $stable(b_q));

    assert_cnt_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cnt == '0);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> state == ST_IDLE && $stable(result));
endmodule

bind quad_add_seq qa_checker #(.DW(DW), .STEPS(STEPS)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .result (result),
    .state  (st),
    .a_q    (a_q),
    .b_q    (b_q),
    .cnt    (cnt)
);

// File: tb/test_quad_add_seq.sv
module test_quad_add_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic [3:0] result;
    logic       done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [3:0] exp_val_q[$];
    int         exp_cyc_q[$];

    quad_add_seq i_quad_add_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_a   (op_a),
        .op_b   (op_b),
        .result (result),
        .done   (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] model(input logic [3:0] a, input logic [3:0] b);
        return 4'(int'(a) * 4 + int'(b));
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            checks++;
            if (exp_val_q.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected done: actual done=1 expected done=0");
            end else begin
                logic [3:0] ev;
                int ec;
                ev = exp_val_q.pop_front();
                ec = exp_cyc_q.pop_front();
                // result after load and four adds: R2 R3 R5
                if (result !== ev) begin
                    errors++;
                    $display("FAIL R5 result: actual %0d expected %0d", result, ev);
                end
                checks++;
                if (cyc != ec) begin
                    errors++;
                    $display("FAIL R4 done cycle: actual %0d expected %0d", cyc, ec);
                end
            end
        end
    end

    // called at a negedge with the block idle; returns on the first idle negedge after done
    task automatic run(input logic [3:0] a, input logic [3:0] b, input bit disturb);
        op_a = a;
        op_b = b;
        start = 1'b1;
        exp_val_q.push_back(model(a, b));
        exp_cyc_q.push_back(cyc + 6);
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            @(negedge clk);
            op_a = ~a;
            op_b = ~b;
            start = 1'b1;   // R7: ignored mid-run
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic hold_check(input logic [3:0] ev, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            checks++;
            if (result !== ev || done !== 1'b0) begin
                errors++;
                $display("FAIL R6 R9 hold: actual result=%0d done=%0b expected result=%0d done=0",
                         result, done, ev);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (result !== 4'd0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset: actual result=%0d done=%0b expected 0/0", result, done);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (result !== 4'd0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R1 after reset: actual result=%0d done=%0b expected 0/0", result, done);
        end
        hold_check(4'd0, 4);                 // R9 idle with start low

        run(4'd1, 4'd2, 1'b0);
        run(4'd3, 4'd5, 1'b0);               // R8 back-to-back
        run(4'd0, 4'd0, 1'b0);
        run(4'd15, 4'd15, 1'b0);             // R5 wraps: 75 mod 16 = 11
        run(4'd4, 4'd0, 1'b0);               // R5 wraps to 0
        hold_check(model(4'd4, 4'd0), 6);    // R6
        run(4'd7, 4'd9, 1'b1);               // R7 disturbed run
        hold_check(model(4'd7, 4'd9), 6);    // R7 no extra done
        run(4'd2, 4'd13, 1'b1);
        run(4'd9, 4'd1, 1'b0);               // R8
        hold_check(model(4'd9, 4'd1), 8);    // R6 R9

        checks++;
        if (exp_val_q.size() != 0) begin
            errors++;
            $display("FAIL R4 missing done: actual pending=%0d expected 0", exp_val_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule